// File: doc/BRIEF.md
# Software-Managed Translation Buffer

This block holds sixteen fully associative translation entries that system software loads, inspects and searches. Each entry covers a pair of adjacent virtual pages: it stores one virtual page number and one address-space identifier for the pair, a global flag, and a separate page descriptor for the even and the odd page. A descriptor has a valid flag, a dirty flag, a three-bit cache attribute and a physical frame number. The frame number is counted in units of physical address bit 12.

Software exchanges data with the block through five 32-bit register images. The tag image carries the virtual page number and the address-space identifier. The even and odd images carry the page descriptors. The size image carries the page mask. The slot image carries the entry number. The block takes four commands, each on a one-cycle strobe:
- A probe searches every entry at once and writes the result back to the slot image.
- A read copies one entry back to the tag, even, odd and size images.
- A slot write loads the entry named by the slot image.
- A random write loads the entry named by a separate random-slot input.

Top module: `tlb_sw_managed`

## Requirements
- R1: After reset every entry is cleared: its page number, identifier, mask, descriptors and global flag are zero. Both result strobes and all output images are zero.
- R2: A slot write or a read addresses the entry given by `slot_in[3:0]`, and the upper slot bits are ignored. A write stores the page number from `tag_in[31:13]` and the identifier from `tag_in[7:0]`. A read returns them at the same positions, with `tag_out[12:8]` zero.
- R3: Each descriptor image holds valid in bit 1, dirty in bit 2, the cache attribute in bits 5:3 and the frame number in bits 29:6. A read returns these fields at the same positions, with bits 31:30 zero.
- R4: The stored global flag is the AND of bit 0 of the even image and bit 0 of the odd image. A read returns bit 0 of both descriptor images as zero.
- R5: The page mask is stored from `size_in[24:13]`. A read returns it at the same bits, with every other bit of `size_out` zero.
- R6: A random write loads the entry named by `rnd_slot` and leaves the entry named by `slot_in` unchanged.
- R7: A probe hits an entry whose page number equals `tag_in[31:13]` and that is either global or has an identifier equal to `tag_in[7:0]`. The valid flags are not consulted. On a hit, `slot_out` is the entry number and its upper bits are zero.
- R8: A probe that hits nothing returns `slot_in` with bit 31 set and every other bit unchanged.
- R9: When several entries hit, the probe returns the lowest entry number.
- R10: A probe or read result appears one cycle after its strobe, with `slot_upd` (probe) or `regs_upd` (read) high for exactly that cycle. A write is visible to a command issued in the very next cycle.
- R11: `cmd_op` is encoded as 0 probe, 1 read, 2 slot write, 3 random write. Write commands and idle cycles raise neither result strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 2 | Command code (R11) |
| slot_in | input | 32 | Slot image: entry number for indexed commands, base value on a probe miss |
| tag_in | input | 32 | Tag image: page number and address-space identifier |
| even_in | input | 32 | Even page descriptor image |
| odd_in | input | 32 | Odd page descriptor image |
| size_in | input | 32 | Page mask image |
| rnd_slot | input | 4 | Entry number used by a random write |
| slot_upd | output | 1 | Probe result valid on slot_out |
| slot_out | output | 32 | Probe result |
| regs_upd | output | 1 | Read result valid on the four image outputs |
| tag_out | output | 32 | Rebuilt tag image |
| even_out | output | 32 | Rebuilt even descriptor image |
| odd_out | output | 32 | Rebuilt odd descriptor image |
| size_out | output | 32 | Rebuilt page mask image |

## Verification
The bench builds the block at its default of sixteen entries. At that size the lowest and highest entry numbers can both be written, probed and read back. A probe can also find every entry sharing a page number, so the priority order can be tested both ways round: first the low entry wins, then it is rewritten and the higher entry takes over. Reset leaves all sixteen entries with page number zero and identifier zero. As a result, a probe for page zero right after reset exercises the priority across the whole array at once.

// File: rtl/tlb_pkg.sv
// Shared types for the software-managed translation buffer.
// Assumes 32-bit register images; descriptor fields fill bits 29:0.
package tlb_pkg;
    localparam int unsigned VPN_W    = 19;
    localparam int unsigned ASID_W   = 8;
    localparam int unsigned PFN_W    = 24;
    localparam int unsigned CATTR_W  = 3;
    localparam int unsigned MASK_W   = 12;
    localparam int unsigned MASK_LSB = 13;
    localparam int unsigned DESC_TOP = 6 + PFN_W;

    typedef enum logic [1:0] {
        CMD_PROBE  = 2'd0,
        CMD_READ   = 2'd1,
        CMD_WR_IDX = 2'd2,
        CMD_WR_RND = 2'd3
    } tlb_cmd_e;

    typedef struct packed {
        logic [PFN_W-1:0]   pfn;
        logic [CATTR_W-1:0] cattr;
        logic               dirty;
        logic               valid;
    } page_desc_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [MASK_W-1:0] mask;
        page_desc_t        even;
        page_desc_t        odd;
    } tlb_entry_t;

    // Extract descriptor fields from a register image.
    function automatic page_desc_t desc_unpack(input logic [31:0] img);
        page_desc_t d;
        d.valid = img[1];
        d.dirty = img[2];
        d.cattr = img[5:3];
        d.pfn   = img[DESC_TOP-1:6];
        return d;
    endfunction

    // Rebuild a register image from descriptor fields; bit 0 reads zero.
    function automatic logic [31:0] desc_pack(input page_desc_t d);
        logic [31:0] img;
        img = '0;
        img[1] = d.valid;
        img[2] = d.dirty;
        img[5:3] = d.cattr;
        img[DESC_TOP-1:6] = d.pfn;
        return img;
    endfunction
endpackage

// File: rtl/tlb_entry_store.sv
// Entry storage: one write port, one combinational read port, and all
// entries exposed flat for the parallel probe. Assumes wr_idx < ENTRIES.
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned IDX_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  tlb_entry_t               wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output tlb_entry_t               rd_data,
    output tlb_entry_t [ENTRIES-1:0] entries_o
);
    tlb_entry_t [ENTRIES-1:0] mem_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        // Clear on reset, load when this slot is addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                mem_q[g] <= wr_data;
            end
        end
    end

    // Indexed read selection.
    always_comb begin
        rd_data = mem_q[rd_idx];
    end

    assign entries_o = mem_q;
endmodule

// File: rtl/tlb_probe_match.sv
// Parallel tag compare across every entry followed by a lowest-index
// priority encoder. Purely combinational; valid flags are not consulted.
module tlb_probe_match
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned IDX_W   = 4
) (
    input  tlb_entry_t [ENTRIES-1:0] entries_i,
    input  logic [VPN_W-1:0]         vpn_i,
    input  logic [ASID_W-1:0]        asid_i,
    output logic                     hit_o,
    output logic [IDX_W-1:0]         hit_idx_o
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = (entries_i[g].vpn == vpn_i) &&
                          (entries_i[g].glob || (entries_i[g].asid == asid_i));
    end

    // Pick the lowest-numbered matching entry.
    always_comb begin
        hit_o     = |match;
        hit_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_sw_managed.sv
// Software-managed translation buffer top. Decodes one command per cycle,
// writes entries, and registers probe and read results for one cycle.
// Assumes at most one command per strobe and rnd_slot < ENTRIES.
module tlb_sw_managed
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [31:0] slot_in,
    input  logic [31:0] tag_in,
    input  logic [31:0] even_in,
    input  logic [31:0] odd_in,
    input  logic [31:0] size_in,
    input  logic [3:0]  rnd_slot,
    output logic        slot_upd,
    output logic [31:0] slot_out,
    output logic        regs_upd,
    output logic [31:0] tag_out,
    output logic [31:0] even_out,
    output logic [31:0] odd_out,
    output logic [31:0] size_out
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int unsigned GAP_W = 32 - VPN_W - ASID_W;

    tlb_cmd_e                 cmd;
    logic                     do_probe, do_read, do_write;
    logic [IDX_W-1:0]         wr_idx;
    tlb_entry_t               wr_data, rd_data;
    tlb_entry_t [ENTRIES-1:0] all_entries;
    logic                     hit;
    logic [IDX_W-1:0]         hit_idx;
    logic                     unused_pins;

    // Command decode.
    always_comb begin
        cmd      = tlb_cmd_e'(cmd_op);
        do_probe = cmd_valid && (cmd == CMD_PROBE);
        do_read  = cmd_valid && (cmd == CMD_READ);
        do_write = cmd_valid && ((cmd == CMD_WR_IDX) || (cmd == CMD_WR_RND));
        wr_idx   = (cmd == CMD_WR_RND) ? IDX_W'(rnd_slot) : slot_in[IDX_W-1:0];
    end

    // Assemble the entry to store from the register images.
    always_comb begin
        wr_data.vpn  = tag_in[31 -: VPN_W];
        wr_data.asid = tag_in[ASID_W-1:0];
        wr_data.glob = even_in[0] & odd_in[0];
        wr_data.mask = size_in[MASK_LSB +: MASK_W];
        wr_data.even = desc_unpack(even_in);
        wr_data.odd  = desc_unpack(odd_in);
    end

    assign unused_pins = ^{tag_in[31-VPN_W:ASID_W], even_in[31:DESC_TOP],
                           odd_in[31:DESC_TOP], size_in[31:MASK_LSB+MASK_W],
                           size_in[MASK_LSB-1:0]};

    tlb_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (do_write),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (slot_in[IDX_W-1:0]),
        .rd_data   (rd_data),
        .entries_o (all_entries)
    );

    tlb_probe_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_probe (
        .entries_i (all_entries),
        .vpn_i     (tag_in[31 -: VPN_W]),
        .asid_i    (tag_in[ASID_W-1:0]),
        .hit_o     (hit),
        .hit_idx_o (hit_idx)
    );

    // Register probe result: entry number on hit, slot image with bit 31 on miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_upd <= 1'b0;
            slot_out <= '0;
        end else begin
            slot_upd <= do_probe;
            if (do_probe) begin
                slot_out <= hit ? 32'(hit_idx) : (slot_in | 32'h8000_0000);
            end
        end
    end

    // Register read result: rebuild the four register images.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_upd <= 1'b0;
            tag_out  <= '0;
            even_out <= '0;
            odd_out  <= '0;
            size_out <= '0;
        end else begin
            regs_upd <= do_read;
            if (do_read) begin
                tag_out  <= {rd_data.vpn, {GAP_W{1'b0}}, rd_data.asid};
                even_out <= desc_pack(rd_data.even);
                odd_out  <= desc_pack(rd_data.odd);
                size_out <= 32'(rd_data.mask) << MASK_LSB;
            end
        end
    end
endmodule

// File: rtl/tlb_sw_managed_chk.sv
// Protocol checker for tlb_sw_managed, attached by bind below.
module tlb_sw_managed_chk
    import tlb_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [1:0]  cmd_op,
    input logic [31:0] slot_in,
    input logic        slot_upd,
    input logic [31:0] slot_out,
    input logic        regs_upd,
    input logic [31:0] tag_out,
    input logic [31:0] even_out,
    input logic [31:0] odd_out
);
    AST_PROBE_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0) |=> (slot_upd && !regs_upd)); // R10
    AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1) |=> (regs_upd && !slot_upd)); // R10
    AST_QUIET_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && !cmd_op[1]) |=> (!slot_upd && !regs_upd)); // R11
    AST_MISS_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_upd && slot_out[31]) |-> (slot_out[30:0] == $past(slot_in[30:0]))); // R8
    AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_upd && !slot_out[31]) |-> ((slot_out >> IDX_W) == 32'd0)); // R7
    AST_READ_GLOBAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        regs_upd |-> (!even_out[0] && !odd_out[0])); // R4
    AST_READ_TAG_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        regs_upd |-> (tag_out[31-VPN_W:ASID_W] == '0)); // R2
endmodule

bind tlb_sw_managed tlb_sw_managed_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .slot_in   (slot_in),
    .slot_upd  (slot_upd),
    .slot_out  (slot_out),
    .regs_upd  (regs_upd),
    .tag_out   (tag_out),
    .even_out  (even_out),
    .odd_out   (odd_out)
);

// File: tb/sim_tlb_sw_managed.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task predicts results from a bench-side
// entry model and queues them; the monitor pops and compares each result.
module sim_tlb_sw_managed;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] slot_in = '0, tag_in = '0, even_in = '0, odd_in = '0, size_in = '0;
    logic [3:0]  rnd_slot = '0;
    logic        slot_upd, regs_upd;
    logic [31:0] slot_out, tag_out, even_out, odd_out, size_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_probe;
        logic [31:0] slot, tag, even, odd, size;
        string       req;
    } exp_t;
    exp_t q[$];
    exp_t mon_e;

    logic [31:0] m_tag[16], m_even[16], m_odd[16], m_size[16];
    bit          m_g[16];

    always #2.5 clk = ~clk;

    tlb_sw_managed u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .slot_in(slot_in), .tag_in(tag_in), .even_in(even_in), .odd_in(odd_in),
        .size_in(size_in), .rnd_slot(rnd_slot), .slot_upd(slot_upd),
        .slot_out(slot_out), .regs_upd(regs_upd), .tag_out(tag_out),
        .even_out(even_out), .odd_out(odd_out), .size_out(size_out)
    );

    // Drive one command and predict its effect from the requirements.
    task automatic issue(input logic [1:0] op, input logic [31:0] slot, tag,
                         input logic [31:0] ev, od, sz, input logic [3:0] rnd,
                         input string req);
        exp_t e;
        int   s;
        bit   found;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; slot_in = slot; tag_in = tag;
        even_in = ev; odd_in = od; size_in = sz; rnd_slot = rnd;
        e.req = req;
        case (op)
            2'd0: begin
                found = 1'b0;
                e.is_probe = 1'b1;
                e.slot = slot | 32'h8000_0000;
                for (int i = 0; i < 16; i++) begin
                    if (!found && m_tag[i][31:13] == tag[31:13] &&
                        (m_g[i] || m_tag[i][7:0] == tag[7:0])) begin
                        found = 1'b1;
                        e.slot = i;
                    end
                end
                q.push_back(e);
            end
            2'd1: begin
                s = int'(slot[3:0]);
                e.is_probe = 1'b0;
                e.tag = m_tag[s]; e.even = m_even[s]; e.odd = m_odd[s]; e.size = m_size[s];
                q.push_back(e);
            end
            default: begin
                s = (op == 2'd3) ? int'(rnd) : int'(slot[3:0]);
                m_tag[s]  = tag & 32'hFFFF_E0FF;
                m_even[s] = ev & 32'h3FFF_FFFE;
                m_odd[s]  = od & 32'h3FFF_FFFE;
                m_size[s] = sz & 32'h01FF_E000;
                m_g[s]    = ev[0] & od[0];
            end
        endcase
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
        end
    endtask

    // Monitor: compare every result strobe against the queue head.
    always @(negedge clk) begin
        if (rst_n && !done && (slot_upd || regs_upd)) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected strobe slot_upd=%b regs_upd=%b expected none",
                         slot_upd, regs_upd);
            end else begin
                mon_e = q.pop_front();
                if (mon_e.is_probe) begin
                    if (!slot_upd || regs_upd || slot_out !== mon_e.slot) begin
                        errors++;
                        $display("FAIL %s probe strobe=%b/%b slot=%08h expected slot=%08h",
                                 mon_e.req, slot_upd, regs_upd, slot_out, mon_e.slot);
                    end
                end else begin
                    if (!regs_upd || slot_upd || tag_out !== mon_e.tag ||
                        even_out !== mon_e.even || odd_out !== mon_e.odd ||
                        size_out !== mon_e.size) begin
                        errors++;
                        $display("FAIL %s read %08h %08h %08h %08h expected %08h %08h %08h %08h",
                                 mon_e.req, tag_out, even_out, odd_out, size_out,
                                 mon_e.tag, mon_e.even, mon_e.odd, mon_e.size);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL R10 watchdog expired at 5000 cycles expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_tag[i] = '0; m_even[i] = '0; m_odd[i] = '0; m_size[i] = '0; m_g[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        // R1: outputs cleared while in reset
        checks++;
        if (slot_upd || regs_upd || slot_out != 0 || tag_out != 0 || size_out != 0) begin
            errors++;
            $display("FAIL R1 reset outputs upd=%b/%b slot=%08h tag=%08h expected all zero",
                     slot_upd, regs_upd, slot_out, tag_out);
        end
        rst_n = 1'b1;
        issue(2'd1, 32'h5, 0, 0, 0, 0, 4'd0, "R1");                       // cleared entry
        issue(2'd0, 32'h3, 32'h0, 0, 0, 0, 4'd0, "R9 R7");                // all match, 0 wins
        issue(2'd2, 32'h7FFF_FFF3, 32'hABCD_FF5A, 32'hFFFF_FFFF,
              32'h1234_5678, 32'hFFFF_FFFF, 4'd0, "R2");
        issue(2'd1, 32'h3, 0, 0, 0, 0, 4'd0, "R10 R2 R3 R4 R5");          // back-to-back read
        issue(2'd3, 32'h3, 32'h0040_2011, 32'h0000_0047, 32'h0000_0019,
              32'h0000_6000, 4'd9, "R6");
        issue(2'd1, 32'h3, 0, 0, 0, 0, 4'd0, "R6");                       // slot 3 untouched
        issue(2'd1, 32'hFFFF_FFF9, 0, 0, 0, 0, 4'd0, "R6 R2");            // slot 9 loaded
        idle(2);
        issue(2'd0, 32'h0, 32'hABCD_E05A, 0, 0, 0, 4'd0, "R7");           // ASID hit
        issue(2'd0, 32'h7, 32'hABCD_E033, 0, 0, 0, 4'd0, "R8");           // ASID mismatch
        issue(2'd0, 32'h0, 32'h0040_20EE, 0, 0, 0, 4'd0, "R7");           // global hit
        issue(2'd2, 32'hC, 32'h7700_0044, 0, 0, 0, 4'd0, "R9");
        issue(2'd2, 32'h4, 32'h7700_0044, 0, 0, 0, 4'd0, "R9");
        issue(2'd0, 32'h0, 32'h7700_0044, 0, 0, 0, 4'd0, "R9");           // 4 over 12
        issue(2'd2, 32'h4, 32'h7700_0045, 0, 0, 0, 4'd0, "R9");
        issue(2'd0, 32'h0, 32'h7700_0044, 0, 0, 0, 4'd0, "R9 R10");       // now 12
        issue(2'd0, 32'h8000_000F, 32'h1234_0000, 0, 0, 0, 4'd0, "R8");
        issue(2'd0, 32'h5555_5555, 32'h1234_0000, 0, 0, 0, 4'd0, "R8");
        idle(4);
        // R11: every predicted result arrived, nothing left pending
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R11 pending results=%0d expected 0", q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule